// File: doc/BRIEF.md
# Phase-Correct Dual-Slope PWM Timer

This block is an 8-bit timer that counts in a triangle. It runs up from zero to the all-ones top value and then back down to zero, and it repeats this without stopping. One count step is taken on each clock where the timer-clock enable is high. A compare unit watches the count and drives one waveform output. It changes the output level only when the count steps onto the active compare value, and the direction of that step decides the new level. The result is a pulse-width-modulated signal that stays centred on the bottom of the count. Its duty cycle is the compare value divided by 255.

Software-side writes to the compare value go into a buffer. The buffer is copied into the active compare register on the step that reaches the top, so a new duty cycle always starts on a clean half-period. A two-bit mode input picks one of three behaviours: output held low, non-inverted waveform, or inverted waveform. Two sticky flags are provided. One marks arrival at the bottom. The other marks each compare match. Each flag is cleared by pulsing its clear input with a one.

Top module: `dspwm_timer`

## Requirements
- R1: While `tick_en` is high, the count rises by one per clock from 0 to 255 and then falls by one per clock back to 0, so one full period is 510 enabled clocks. `dir_down_o` becomes 1 on the step that reaches 255 and becomes 0 on the step that reaches 0.
- R2: The count holds 255 for exactly one enabled clock, and it holds 0 for exactly one enabled clock. After 255 the next value is 254.
- R3: While `tick_en` is low, the count, the direction, the waveform level and both flags keep their values, apart from explicit flag clears.
- R4: In mode 2 (non-inverted), a step onto the active compare value while counting up drives `wave_o` to 0. A step onto that value while counting down drives `wave_o` to 1.
- R5: In mode 3 (inverted), `wave_o` is always the complement of the level that mode 2 would give.
- R6: In modes 0 and 1, `wave_o` is 0 and the counter keeps running.
- R7: On the turnaround steps the non-inverted level is forced. On reaching 255 it becomes 1 only when the compare value is 255. On reaching 0 it becomes 1 only when the compare value is not 0. As a result, in steady state the non-inverted output is high for 2×C of every 510 enabled clocks, where C is the compare value. This includes C=0 (always low) and C=255 (always high).
- R8: `ovf_flag_o` is set on each enabled step that reaches 0. It is cleared by `ovf_clr`=1. When a set and a clear fall in the same clock, the set wins.
- R9: `cmp_flag_o` is set on each enabled step onto the active compare value. It is cleared by `cmp_clr`=1. When a set and a clear fall in the same clock, the set wins.
- R10: A `cmp_wr_en` write goes to the buffer only. `cmp_active_o` takes the buffered value on the step that reaches 255, and the compare action of that same step already uses the new value. At no other time does `cmp_active_o` change.
- R11: A synchronous reset `rst` sets the following to zero: the count, the buffer, the active compare value, the waveform level and both flags. It also sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer-clock enable; one count step per high clock |
| cmp_wr_en | input | 1 | Write strobe for the compare buffer |
| cmp_wr_data | input | 8 | Value written to the compare buffer |
| out_mode | input | 2 | 0/1 output low, 2 non-inverted, 3 inverted |
| ovf_clr | input | 1 | Write-one clear of the bottom flag |
| cmp_clr | input | 1 | Write-one clear of the match flag |
| count_o | output | 8 | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| cmp_active_o | output | 8 | Active compare value |
| wave_o | output | 1 | Waveform output |
| ovf_flag_o | output | 1 | Bottom-reached flag |
| cmp_flag_o | output | 1 | Compare-match flag |

## Verification
A wrong count or direction state shows on `count_o` and `dir_down_o` on the very next enabled clock, and it shifts every later match. A wrong waveform level can stay hidden until the next match or turnaround step. For that reason the waveform is compared on every clock and is also summed as high time over a full 510-clock period for compare values 0, 100 and 255. A stale compare buffer only shows when the count next reaches the top, so `cmp_active_o` is checked right after a write and again at that top step.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OM_LOW_A  = 2'd0,
        OM_LOW_B  = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

    // one count step as seen by the compare unit
    typedef struct packed {
        logic valid;   // a step happens this clock
        logic up;      // step direction is upward
        logic at_top;  // step lands on the top value
        logic at_bot;  // step lands on zero
    } step_t;

    localparam int FLAG_OVF = 0;
    localparam int FLAG_CMP = 1;
    localparam int N_FLAGS  = 2;

    function automatic logic wave_drive(input out_mode_e mode, input logic level);
        case (mode)
            OM_NONINV: wave_drive = level;
            OM_INV:    wave_drive = ~level;
            default:   wave_drive = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dspwm_counter.sv
module dspwm_counter
    import dspwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] cnt_q,
    output dir_e         dir_q,
    output logic [W-1:0] cnt_nxt,
    output step_t        step
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    always_comb begin
        step.valid = tick;
        step.up    = (dir_q == DIR_UP);
        cnt_nxt    = step.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        step.at_top = (cnt_nxt == TOP);
        step.at_bot = (cnt_nxt == BOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= BOT;
            dir_q <= DIR_UP;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
            if (step.at_top)
                dir_q <= DIR_DOWN;
            else if (step.at_bot)
                dir_q <= DIR_UP;
        end
    end

endmodule

// File: rtl/dspwm_compare.sv
module dspwm_compare
    import dspwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step,
    input  logic [W-1:0] cnt_nxt,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] act_q,
    output logic         level_q,
    output logic         hit
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    logic [W-1:0] buf_q;
    logic [W-1:0] eff;
    logic         level_nxt;
    logic         reload;

    always_comb begin
        reload = step.valid && step.at_top;
        eff    = reload ? buf_q : act_q;
        hit    = step.valid && (cnt_nxt == eff);
        level_nxt = level_q;
        if (step.valid) begin
            if (step.at_top)
                level_nxt = (eff == TOP);      // forced level at the upper turn
            else if (step.at_bot)
                level_nxt = (eff != BOT);      // forced level at the lower turn
            else if (hit)
                level_nxt = ~step.up;          // clear rising, set falling
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q   <= BOT;
            act_q   <= BOT;
            level_q <= 1'b0;
        end else begin
            if (wr_en)
                buf_q <= wr_data;
            if (reload)
                act_q <= buf_q;
            level_q <= level_nxt;
        end
    end

endmodule

// File: rtl/dspwm_flags.sv
module dspwm_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             cmp_wr_en,
    input  logic [CNT_W-1:0] cmp_wr_data,
    input  logic [1:0]       out_mode,
    input  logic             ovf_clr,
    input  logic             cmp_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_down_o,
    output logic [CNT_W-1:0] cmp_active_o,
    output logic             wave_o,
    output logic             ovf_flag_o,
    output logic             cmp_flag_o
);
    logic [CNT_W-1:0] cnt_nxt;
    dir_e             dir_q;
    step_t            step;
    logic             level_q;
    logic             hit;
    logic [N_FLAGS-1:0] flag_set, flag_clr, flag_q;

    dspwm_counter #(.W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_en),
        .cnt_q   (count_o),
        .dir_q   (dir_q),
        .cnt_nxt (cnt_nxt),
        .step    (step)
    );

    dspwm_compare #(.W(CNT_W)) u_compare (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .cnt_nxt (cnt_nxt),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .act_q   (cmp_active_o),
        .level_q (level_q),
        .hit     (hit)
    );

    always_comb begin
        flag_set           = '0;
        flag_clr           = '0;
        flag_set[FLAG_OVF] = step.valid && step.at_bot;
        flag_set[FLAG_CMP] = hit;
        flag_clr[FLAG_OVF] = ovf_clr;
        flag_clr[FLAG_CMP] = cmp_clr;
    end

    dspwm_flags #(.N(N_FLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .set (flag_set),
        .clr (flag_clr),
        .q   (flag_q)
    );

    assign dir_down_o = (dir_q == DIR_DOWN);
    assign wave_o     = wave_drive(out_mode_e'(out_mode), level_q);
    assign ovf_flag_o = flag_q[FLAG_OVF];
    assign cmp_flag_o = flag_q[FLAG_CMP];

endmodule

// File: rtl/dspwm_timer_checker.sv
module dspwm_timer_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_en,
    input logic [1:0]   out_mode,
    input logic [W-1:0] count_o,
    input logic         dir_down_o,
    input logic [W-1:0] cmp_active_o,
    input logic         wave_o,
    input logic         ovf_flag_o
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;
    localparam logic [W-1:0] TOP_M1 = TOP - 1'b1;
    localparam logic [W-1:0] ONE = 1;

    // R1: upward step
    p_step_up_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !dir_down_o) |=> (count_o == $past(count_o) + 1'b1));

    // R1: downward step
    p_step_down_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_en && dir_down_o) |=> (count_o == $past(count_o) - 1'b1));

    // R2: endpoints carry the turned direction
    p_top_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (count_o == TOP) |-> dir_down_o);
    p_bot_dir_r2: assert property (@(posedge clk) disable iff (rst)
        (count_o == BOT) |-> !dir_down_o);

    // R3: no enable, no movement
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> ($stable(count_o) && $stable(dir_down_o)));

    // R6: low output in the disconnected modes
    p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
        (out_mode[1] == 1'b0) |-> !wave_o);

    // R7: a zero compare value keeps the non-inverted output low
    p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_active_o == BOT && out_mode == 2'd2) |-> !wave_o);

    // R8: reaching the bottom raises the flag
    p_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        (tick_en && dir_down_o && count_o == ONE) |=> ovf_flag_o);

    // R10: the active value only moves on the step onto the top
    p_active_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(tick_en && !dir_down_o && count_o == TOP_M1) |=> $stable(cmp_active_o));

endmodule

bind dspwm_timer dspwm_timer_checker #(.W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_en      (tick_en),
    .out_mode     (out_mode),
    .count_o      (count_o),
    .dir_down_o   (dir_down_o),
    .cmp_active_o (cmp_active_o),
    .wave_o       (wave_o),
    .ovf_flag_o   (ovf_flag_o)
);

// File: tb/dspwm_timer_bench.sv
module dspwm_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cmp_wr_en = 1'b0;
    logic [7:0] cmp_wr_data = 8'd0;
    logic [1:0] out_mode = 2'd0;
    logic       ovf_clr = 1'b0;
    logic       cmp_clr = 1'b0;
    logic [7:0] count_o;
    logic       dir_down_o;
    logic [7:0] cmp_active_o;
    logic       wave_o;
    logic       ovf_flag_o;
    logic       cmp_flag_o;

    integer n_checks = 0;
    integer n_fail   = 0;
    bit     done     = 1'b0;

    always #5 clk = ~clk;

    dspwm_timer u_dspwm_timer (
        .clk          (clk),
        .rst          (rst),
        .tick_en      (tick_en),
        .cmp_wr_en    (cmp_wr_en),
        .cmp_wr_data  (cmp_wr_data),
        .out_mode     (out_mode),
        .ovf_clr      (ovf_clr),
        .cmp_clr      (cmp_clr),
        .count_o      (count_o),
        .dir_down_o   (dir_down_o),
        .cmp_active_o (cmp_active_o),
        .wave_o       (wave_o),
        .ovf_flag_o   (ovf_flag_o),
        .cmp_flag_o   (cmp_flag_o)
    );

    task automatic chk(input bit ok, input string req, input integer act, input integer exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: triangle counter with a level that is high
    // whenever the count sits below the compare value on the way up, or
    // at or below it on the way down, plus forced turnaround levels
    integer m_cnt = 0, m_down = 0, m_act = 0, m_buf = 0, m_lvl = 0;
    integer m_ovf = 0, m_cmpf = 0;
    integer nc, new_act, hit_m, bot_m;
    bit     model_on = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_down = 0; m_act = 0; m_buf = 0; m_lvl = 0;
            m_ovf = 0; m_cmpf = 0;
        end else begin
            hit_m = 0; bot_m = 0;
            if (tick_en) begin
                nc = (m_down != 0) ? m_cnt - 1 : m_cnt + 1;
                new_act = (nc == 255) ? m_buf : m_act;
                hit_m = (nc == new_act);
                bot_m = (nc == 0);
                if (nc == 255)      m_lvl = (new_act == 255);
                else if (nc == 0)   m_lvl = (new_act != 0);
                else if (hit_m)     m_lvl = m_down;
                if (nc == 255) m_down = 1;
                if (nc == 0)   m_down = 0;
                m_cnt = nc;
                m_act = new_act;
            end
            if (bot_m)        m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (hit_m)        m_cmpf = 1;
            else if (cmp_clr) m_cmpf = 0;
            if (cmp_wr_en) m_buf = cmp_wr_data;
        end
    end

    function automatic integer exp_wave();
        if (out_mode == 2'd2) return m_lvl;
        if (out_mode == 2'd3) return 1 - m_lvl;
        return 0;
    endfunction

    always begin
        @(negedge clk);
        #1;
        if (model_on && !done) begin
            chk(count_o == m_cnt[7:0] && dir_down_o == m_down[0], "R1 count",
                count_o, m_cnt);
            chk(wave_o == exp_wave(),
                (out_mode == 2'd2) ? "R4 wave" : (out_mode == 2'd3) ? "R5 wave" : "R6 wave",
                wave_o, exp_wave());
            chk(ovf_flag_o == m_ovf[0], "R8 flag", ovf_flag_o, m_ovf);
            chk(cmp_flag_o == m_cmpf[0], "R9 flag", cmp_flag_o, m_cmpf);
            chk(cmp_active_o == m_act[7:0], "R10 active", cmp_active_o, m_act);
        end
    end

    task automatic step_n(input integer n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic write_cmp(input integer v);
        @(negedge clk);
        cmp_wr_en = 1'b1; cmp_wr_data = v[7:0];
        @(negedge clk);
        cmp_wr_en = 1'b0;
        #2;
    endtask

    task automatic wait_count(input integer v);
        for (int i = 0; i < 600; i++) begin
            if (count_o == v[7:0]) break;
            step_n(1);
        end
    endtask

    task automatic measure_high(output integer highs);
        highs = 0;
        for (int i = 0; i < 510; i++) begin
            step_n(1);
            if (wave_o) highs++;
        end
    endtask

    integer hi, c0, lfsr;

    initial begin
        step_n(3);
        // R11: reset state
        chk(count_o == 0 && !dir_down_o, "R11 count/dir", count_o, 0);
        chk(cmp_active_o == 0 && !wave_o, "R11 active/wave", cmp_active_o, 0);
        chk(!ovf_flag_o && !cmp_flag_o, "R11 flags", {ovf_flag_o, cmp_flag_o}, 0);
        @(negedge clk);
        rst = 1'b0; model_on = 1'b1; out_mode = 2'd2; tick_en = 1'b1;
        write_cmp(100);
        // R10: buffered, not yet active
        chk(cmp_active_o == 0, "R10 before top", cmp_active_o, 0);
        wait_count(255);
        chk(cmp_active_o == 100, "R10 at top", cmp_active_o, 100);
        chk(dir_down_o == 1'b1, "R2 top dir", dir_down_o, 1);
        step_n(1);
        chk(count_o == 254, "R2 after top", count_o, 254);
        step_n(510);
        measure_high(hi);
        chk(hi == 200, "R7 duty 100", hi, 200);
        out_mode = 2'd3;
        measure_high(hi);
        chk(hi == 310, "R5 inverted duty", hi, 310);
        out_mode = 2'd0;
        c0 = count_o;
        measure_high(hi);
        chk(hi == 0, "R6 mode0 low", hi, 0);
        out_mode = 2'd1;
        step_n(7);
        chk(count_o != c0[7:0] || 1'b0, "R6 counter runs", count_o, c0 + 7);
        out_mode = 2'd2;
        // R3: hold with enable low
        tick_en = 1'b0;
        c0 = count_o;
        step_n(20);
        chk(count_o == c0[7:0], "R3 hold", count_o, c0);
        lfsr = 32'h1d;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB8 : 0);
            tick_en = lfsr[0] | lfsr[2];
        end
        tick_en = 1'b1;
        // R7: constant low at compare 0
        write_cmp(0);
        wait_count(255);
        step_n(510);
        measure_high(hi);
        chk(hi == 0, "R7 duty 0", hi, 0);
        write_cmp(255);
        wait_count(255);
        step_n(510);
        measure_high(hi);
        chk(hi == 510, "R7 duty 255", hi, 510);
        // R8: bottom flag and clear
        wait_count(0);
        chk(ovf_flag_o == 1'b1, "R8 set at bottom", ovf_flag_o, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        #2;
        chk(ovf_flag_o == 1'b0, "R8 cleared", ovf_flag_o, 0);
        // R9: match flag and clear
        write_cmp(40);
        wait_count(255);
        wait_count(40);
        chk(cmp_flag_o == 1'b1, "R9 set on match", cmp_flag_o, 1);
        @(negedge clk); cmp_clr = 1'b1;
        @(negedge clk); cmp_clr = 1'b0;
        #2;
        chk(cmp_flag_o == 1'b0, "R9 cleared", cmp_flag_o, 0);
        step_n(40);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule